// File: doc/BRIEF.md
# Register Wakeup Scoreboard with Dependent Tracking

This block tracks which physical registers hold a finished result and which waiting instructions depend on registers that do not yet. It keeps one ready bit for each physical register. Each waiting instruction occupies a slot in a small table and has at most two source operands. For each register, the block also keeps the set of slots that still wait on it. At dispatch, any source whose register is already ready counts as satisfied at once. Each remaining source joins the waiting set of its register, and the destination register of the instruction loses its ready bit.

When a producer reports completion of a register, every slot in that register's waiting set is woken. Its count of outstanding sources drops by the number of its operands that named the register, and the waiting set is emptied. The register's ready bit is then set. A slot whose count reaches zero is announced on a single ready port. If several slots become ready together, they are announced one per cycle, lowest slot index first. A squash port removes a slot from every waiting set and from the ready backlog.

Register tags at or above the physical register count are always ready and are never tracked. Such a tag stands for a hard-wired constant register. The dispatch logic assigns the slot index, and that slot must be free. Operand values, renaming and issue selection belong to other blocks.

Top module: `wk_wakeup_sb`

## Requirements
- R1: After reset, every register ready bit reads 0, `wake_valid` is 0 and `dst_conflict` is 0.
- R2: A dispatched slot whose enabled sources all name ready registers (or has no enabled source) is announced on `wake_valid`/`wake_slot` right after the dispatch clock edge.
- R3: A dispatched source whose register is not ready keeps its slot unannounced until that register completes.
- R4: A tag at or above NUM_PREGS (24 by default, so tags 24..31) counts as ready when used as a source, and as a destination it changes no ready bit.
- R5: A dispatched destination with a tag below NUM_PREGS reads 0 in `reg_ready` after the dispatch edge, even if it was 1 before.
- R6: If a dispatched destination register still has waiting slots, and the completion in the same cycle does not name that register, `dst_conflict` is 1 for exactly the cycle after the dispatch edge.
- R7: A completion sets the register's bit in `reg_ready` and wakes every slot waiting on it. A slot whose two sources both name that register becomes ready from that single completion. A slot that waits on two different registers needs both completions.
- R8: A squashed slot is removed from all waiting sets and from the ready backlog. A later completion does not announce it, and its former register no longer counts as having waiting slots.
- R9: When several slots are ready in the same cycle, one is announced per cycle, in ascending slot index. Each announced slot leaves the backlog at the next edge.
- R10: When a completion and a dispatch name the same register in the same cycle, the completion takes effect first. A source naming that register counts as ready. A destination naming it ends with its ready bit at 0 and raises no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch strobe |
| disp_slot | input | SLOT_W | Free slot index taken by the dispatched instruction |
| disp_a_vld | input | 1 | First source enabled |
| disp_a_tag | input | TAG_W | First source register tag |
| disp_b_vld | input | 1 | Second source enabled |
| disp_b_tag | input | TAG_W | Second source register tag |
| disp_d_vld | input | 1 | Destination enabled |
| disp_d_tag | input | TAG_W | Destination register tag |
| done_valid | input | 1 | Producer completion strobe |
| done_tag | input | TAG_W | Completed register tag |
| kill_valid | input | 1 | Squash strobe |
| kill_slot | input | SLOT_W | Slot to squash |
| wake_valid | output | 1 | A ready slot is announced |
| wake_slot | output | SLOT_W | Announced slot index |
| reg_ready | output | NUM_PREGS | Ready bit of each physical register |
| dst_conflict | output | 1 | Destination was dispatched while its waiting set was non-empty |

## Verification
The functions most likely to collide in one cycle are a completion and a dispatch that name the same register. The bench provokes this twice. In the first case the dispatched source names the completing register, and the slot must be announced immediately with no further completion. In the second case the dispatched destination names a register whose only waiting slot is woken by that same completion. That case must raise no conflict, must announce the woken slot before the newly dispatched one, and must leave the ready bit at 0. A second collision, a squash landing on a slot that waits in the ready backlog behind another slot, is judged by watching the announcement skip straight to the next slot.

// File: rtl/wk_pkg.sv
// Shared types and helpers for the register wakeup scoreboard.
// Assumes each waiting slot carries at most two source operands.
package wk_pkg;

    // Outstanding-source count of one slot (0, 1 or 2)
    typedef logic [1:0] pend_cnt_t;

    // Sum of two single-bit source flags as a count
    function automatic pend_cnt_t flag_sum(input logic a, input logic b);
        return pend_cnt_t'({1'b0, a}) + pend_cnt_t'({1'b0, b});
    endfunction

endpackage

// File: rtl/wk_ready_bits.sv
// Per-register ready bits.
// Set by a completion, cleared by a dispatched destination; when both name
// the same register in one cycle the clear wins (completion happens first).
// Assumes tags at or above NUM_PREGS never match any bit.
module wk_ready_bits #(
    parameter int NUM_PREGS = 24,
    parameter int TAG_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_vld,
    input  logic [TAG_W-1:0]     set_tag,
    input  logic                 clr_vld,
    input  logic [TAG_W-1:0]     clr_tag,
    output logic [NUM_PREGS-1:0] rdy_q
);

    // Update each ready bit from completion and dispatch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q <= '0;
        end else begin
            for (int r = 0; r < NUM_PREGS; r++) begin
                if (clr_vld && clr_tag == TAG_W'(r))
                    rdy_q[r] <= 1'b0;
                else if (set_vld && set_tag == TAG_W'(r))
                    rdy_q[r] <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_PREGS; g++) begin : g_chk
        assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vld && set_tag == TAG_W'(g) && !(clr_vld && clr_tag == TAG_W'(g)))
            |=> rdy_q[g]);
        assert_dst_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vld && clr_tag == TAG_W'(g)) |=> !rdy_q[g]);
    end

endmodule

// File: rtl/wk_dep_matrix.sv
// Waiting sets: for each register, one bit per slot and per source position.
// A row is emptied when its register completes; a column is emptied when its
// slot is squashed. Assumes the caller never adds to a row being woken or to
// a slot being squashed in the same cycle.
module wk_dep_matrix #(
    parameter int NUM_PREGS = 24,
    parameter int NUM_SLOTS = 8,
    parameter int TAG_W     = 5,
    parameter int SLOT_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SLOT_W-1:0]    add_slot,
    input  logic                 add0_vld,
    input  logic [TAG_W-1:0]     add0_tag,
    input  logic                 add1_vld,
    input  logic [TAG_W-1:0]     add1_tag,
    input  logic                 wake_vld,
    input  logic [TAG_W-1:0]     wake_tag,
    input  logic                 kill_vld,
    input  logic [SLOT_W-1:0]    kill_slot,
    input  logic [TAG_W-1:0]     q_tag,
    output logic [NUM_SLOTS-1:0] hit0,
    output logic [NUM_SLOTS-1:0] hit1,
    output logic                 q_busy
);

    logic [NUM_SLOTS-1:0] dep0_q [NUM_PREGS];
    logic [NUM_SLOTS-1:0] dep1_q [NUM_PREGS];
    logic [NUM_SLOTS-1:0] col_busy;

    // Read the woken row and test the queried row for waiters
    always_comb begin
        hit0     = '0;
        hit1     = '0;
        q_busy   = 1'b0;
        col_busy = '0;
        for (int r = 0; r < NUM_PREGS; r++) begin
            if (wake_vld && wake_tag == TAG_W'(r)) begin
                hit0 = hit0 | dep0_q[r];
                hit1 = hit1 | dep1_q[r];
            end
            if (q_tag == TAG_W'(r))
                q_busy = q_busy | (|(dep0_q[r] | dep1_q[r]));
            col_busy = col_busy | dep0_q[r] | dep1_q[r];
        end
    end

    // Add new waiters, drain woken rows, drop squashed columns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_PREGS; r++) begin
                dep0_q[r] <= '0;
                dep1_q[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NUM_PREGS; r++) begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (add0_vld && add0_tag == TAG_W'(r) && add_slot == SLOT_W'(s))
                        dep0_q[r][s] <= 1'b1;
                    else if ((kill_vld && kill_slot == SLOT_W'(s)) ||
                             (wake_vld && wake_tag == TAG_W'(r)))
                        dep0_q[r][s] <= 1'b0;
                    if (add1_vld && add1_tag == TAG_W'(r) && add_slot == SLOT_W'(s))
                        dep1_q[r][s] <= 1'b1;
                    else if ((kill_vld && kill_slot == SLOT_W'(s)) ||
                             (wake_vld && wake_tag == TAG_W'(r)))
                        dep1_q[r][s] <= 1'b0;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_PREGS; g++) begin : g_row
        assert_row_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_vld && wake_tag == TAG_W'(g)) |=> (dep0_q[g] == '0 && dep1_q[g] == '0));
    end
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_col
        assert_kill_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (kill_vld && kill_slot == SLOT_W'(g)) |=> !col_busy[g]);
    end

endmodule

// File: rtl/wk_pick_first.sv
// Fixed-priority picker: grants the lowest-index request.
// Purely combinational; assumes nothing about the request pattern.
module wk_pick_first #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             vld,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     gnt
);

    // Scan upward and keep the first request seen
    always_comb begin
        vld = 1'b0;
        idx = '0;
        gnt = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !vld) begin
                vld    = 1'b1;
                idx    = IDX_W'(i);
                gnt[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wk_wakeup_sb.sv
// Register wakeup scoreboard with per-register waiting sets.
// Dispatch records unready sources and clears the destination's ready bit;
// completion wakes waiters then marks the register ready; squash removes a
// slot. Ready slots leave one per cycle, lowest index first.
// Assumes dispatch targets a free slot that is not squashed in the same cycle.
module wk_wakeup_sb #(
    parameter int NUM_PREGS = 24,
    parameter int TAG_W     = 5,
    parameter int NUM_SLOTS = 8,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 disp_valid,
    input  logic [SLOT_W-1:0]    disp_slot,
    input  logic                 disp_a_vld,
    input  logic [TAG_W-1:0]     disp_a_tag,
    input  logic                 disp_b_vld,
    input  logic [TAG_W-1:0]     disp_b_tag,
    input  logic                 disp_d_vld,
    input  logic [TAG_W-1:0]     disp_d_tag,
    input  logic                 done_valid,
    input  logic [TAG_W-1:0]     done_tag,
    input  logic                 kill_valid,
    input  logic [SLOT_W-1:0]    kill_slot,
    output logic                 wake_valid,
    output logic [SLOT_W-1:0]    wake_slot,
    output logic [NUM_PREGS-1:0] reg_ready,
    output logic                 dst_conflict
);
    import wk_pkg::*;

    logic                 a_wait, b_wait, clr_vld, q_busy, conflict_d;
    pend_cnt_t            need_cnt;
    logic [NUM_SLOTS-1:0] hit0, hit1, gnt, pend_q;
    pend_cnt_t            dec   [NUM_SLOTS];
    pend_cnt_t            cnt_q [NUM_SLOTS];

    // Decide which sources must wait, counting a same-cycle completion as ready
    always_comb begin
        a_wait = 1'b0;
        b_wait = 1'b0;
        for (int r = 0; r < NUM_PREGS; r++) begin
            if (disp_a_tag == TAG_W'(r))
                a_wait = disp_a_vld && !(reg_ready[r] || (done_valid && done_tag == disp_a_tag));
            if (disp_b_tag == TAG_W'(r))
                b_wait = disp_b_vld && !(reg_ready[r] || (done_valid && done_tag == disp_b_tag));
        end
        need_cnt   = flag_sum(a_wait, b_wait);
        clr_vld    = disp_valid && disp_d_vld && (int'(disp_d_tag) < NUM_PREGS);
        conflict_d = clr_vld && q_busy && !(done_valid && done_tag == disp_d_tag);
        for (int s = 0; s < NUM_SLOTS; s++)
            dec[s] = flag_sum(hit0[s], hit1[s]);
    end

    wk_ready_bits #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .set_vld(done_valid), .set_tag(done_tag),
        .clr_vld(clr_vld), .clr_tag(disp_d_tag),
        .rdy_q(reg_ready)
    );

    wk_dep_matrix #(.NUM_PREGS(NUM_PREGS), .NUM_SLOTS(NUM_SLOTS),
                    .TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_deps (
        .clk(clk), .rst_n(rst_n),
        .add_slot(disp_slot),
        .add0_vld(disp_valid && a_wait), .add0_tag(disp_a_tag),
        .add1_vld(disp_valid && b_wait), .add1_tag(disp_b_tag),
        .wake_vld(done_valid), .wake_tag(done_tag),
        .kill_vld(kill_valid), .kill_slot(kill_slot),
        .q_tag(disp_d_tag),
        .hit0(hit0), .hit1(hit1), .q_busy(q_busy)
    );

    wk_pick_first #(.N(NUM_SLOTS), .IDX_W(SLOT_W)) u_pick (
        .req(pend_q), .vld(wake_valid), .idx(wake_slot), .gnt(gnt)
    );

    // Track outstanding-source counts and the ready backlog of each slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            for (int s = 0; s < NUM_SLOTS; s++) cnt_q[s] <= '0;
        end else begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (kill_valid && kill_slot == SLOT_W'(s)) begin
                    cnt_q[s]  <= '0;
                    pend_q[s] <= 1'b0;
                end else if (disp_valid && disp_slot == SLOT_W'(s)) begin
                    cnt_q[s]  <= need_cnt;
                    pend_q[s] <= (need_cnt == '0);
                end else begin
                    if (gnt[s]) pend_q[s] <= 1'b0;
                    if (dec[s] != '0) begin
                        cnt_q[s] <= cnt_q[s] - dec[s];
                        if (cnt_q[s] == dec[s]) pend_q[s] <= 1'b1;
                    end
                end
            end
        end
    end

    // Register the destination-conflict pulse
    always_ff @(posedge clk) begin
        if (!rst_n) dst_conflict <= 1'b0;
        else        dst_conflict <= conflict_d;
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (reg_ready == '0 && !wake_valid && !dst_conflict));
    assert_no_source_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_a_vld && !disp_b_vld && !kill_valid) |=> wake_valid);
    assert_untracked_dst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_d_vld && int'(disp_d_tag) >= NUM_PREGS && !done_valid)
        |=> reg_ready == $past(reg_ready));
    assert_conflict_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dst_conflict |-> $past(disp_valid && disp_d_vld));
    assert_wake_advances_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_valid && !disp_valid) |=> (!wake_valid || wake_slot != $past(wake_slot)));

endmodule

// File: tb/wk_wakeup_sb_tb.sv
module wk_wakeup_sb_tb;
    localparam int NUM_PREGS = 24;
    localparam int TAG_W     = 5;
    localparam int NUM_SLOTS = 8;
    localparam int SLOT_W    = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic disp_valid, disp_a_vld, disp_b_vld, disp_d_vld, done_valid, kill_valid;
    logic [SLOT_W-1:0] disp_slot, kill_slot, wake_slot;
    logic [TAG_W-1:0]  disp_a_tag, disp_b_tag, disp_d_tag, done_tag;
    logic wake_valid, dst_conflict;
    logic [NUM_PREGS-1:0] reg_ready;
    logic [NUM_PREGS-1:0] exp_rdy;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wk_wakeup_sb #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W), .NUM_SLOTS(NUM_SLOTS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_slot(disp_slot),
        .disp_a_vld(disp_a_vld), .disp_a_tag(disp_a_tag),
        .disp_b_vld(disp_b_vld), .disp_b_tag(disp_b_tag),
        .disp_d_vld(disp_d_vld), .disp_d_tag(disp_d_tag),
        .done_valid(done_valid), .done_tag(done_tag),
        .kill_valid(kill_valid), .kill_slot(kill_slot),
        .wake_valid(wake_valid), .wake_slot(wake_slot),
        .reg_ready(reg_ready), .dst_conflict(dst_conflict)
    );

    task automatic clr_in();
        disp_valid = 0; disp_slot = '0; disp_a_vld = 0; disp_a_tag = '0;
        disp_b_vld = 0; disp_b_tag = '0; disp_d_vld = 0; disp_d_tag = '0;
        done_valid = 0; done_tag = '0; kill_valid = 0; kill_slot = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        clr_in();
    endtask

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_wake(string req, bit v, int slot);
        check(req, "wake_valid", int'(wake_valid), int'(v));
        if (v) check(req, "wake_slot", int'(wake_slot), slot);
    endtask

    task automatic dispatch(int slot, bit av, int at, bit bv, int bt, bit dv, int dt);
        disp_valid = 1; disp_slot = SLOT_W'(slot);
        disp_a_vld = av; disp_a_tag = TAG_W'(at);
        disp_b_vld = bv; disp_b_tag = TAG_W'(bt);
        disp_d_vld = dv; disp_d_tag = TAG_W'(dt);
    endtask

    task automatic complete(int tag);
        done_valid = 1; done_tag = TAG_W'(tag);
    endtask

    task automatic t_reset();
        check("R1", "reg_ready", int'(reg_ready), 0);
        chk_wake("R1", 0, 0);
        check("R1", "dst_conflict", int'(dst_conflict), 0);
    endtask

    task automatic t_ready_at_dispatch();
        complete(5); step(); exp_rdy[5] = 1;
        check("R7", "reg_ready[5]", int'(reg_ready[5]), 1);
        dispatch(0, 1, 5, 0, 0, 0, 0); step();
        chk_wake("R2", 1, 0);
        step(); chk_wake("R2", 0, 0);
    endtask

    task automatic t_wait_two_regs();
        dispatch(2, 0, 0, 0, 0, 1, 5); step(); exp_rdy[5] = 0;
        chk_wake("R2", 1, 2);
        check("R5", "reg_ready[5]", int'(reg_ready[5]), 0);
        dispatch(1, 1, 5, 1, 8, 0, 0); step();
        chk_wake("R3", 0, 0);
        complete(5); step(); exp_rdy[5] = 1;
        chk_wake("R7", 0, 0);
        complete(8); step(); exp_rdy[8] = 1;
        chk_wake("R7", 1, 1);
        step(); chk_wake("R3", 0, 0);
    endtask

    task automatic t_same_reg_twice();
        dispatch(3, 1, 9, 1, 9, 0, 0); step();
        chk_wake("R3", 0, 0);
        complete(9); step(); exp_rdy[9] = 1;
        chk_wake("R7", 1, 3);
        step();
    endtask

    task automatic t_untracked();
        dispatch(4, 1, 30, 1, 31, 1, 29); step();
        chk_wake("R4", 1, 4);
        check("R4", "reg_ready", int'(reg_ready), int'(exp_rdy));
        step();
    endtask

    task automatic t_conflict();
        dispatch(5, 1, 10, 0, 0, 0, 0); step();
        chk_wake("R3", 0, 0);
        dispatch(6, 0, 0, 0, 0, 1, 10); step();
        check("R6", "dst_conflict", int'(dst_conflict), 1);
        chk_wake("R2", 1, 6);
        step();
        check("R6", "dst_conflict pulse", int'(dst_conflict), 0);
        dispatch(6, 0, 0, 0, 0, 1, 20); step();
        check("R6", "dst_conflict empty set", int'(dst_conflict), 0);
        step();
        complete(10); step(); exp_rdy[10] = 1;
        chk_wake("R7", 1, 5);
        check("R7", "reg_ready", int'(reg_ready), int'(exp_rdy));
        step();
    endtask

    task automatic t_squash();
        dispatch(0, 1, 11, 0, 0, 0, 0); step();
        kill_valid = 1; kill_slot = 0; step();
        complete(11); step(); exp_rdy[11] = 1;
        chk_wake("R8", 0, 0);
        dispatch(1, 0, 0, 0, 0, 1, 11); step(); exp_rdy[11] = 0;
        check("R8", "dst_conflict", int'(dst_conflict), 0);
        chk_wake("R2", 1, 1);
        check("R5", "reg_ready[11]", int'(reg_ready[11]), 0);
        step();
    endtask

    task automatic t_burst();
        dispatch(7, 1, 12, 0, 0, 0, 0); step();
        dispatch(3, 1, 12, 0, 0, 0, 0); step();
        dispatch(5, 1, 12, 0, 0, 0, 0); step();
        chk_wake("R3", 0, 0);
        complete(12); step(); exp_rdy[12] = 1;
        chk_wake("R9", 1, 3);
        kill_valid = 1; kill_slot = 5; step();
        chk_wake("R8", 1, 7);
        step(); chk_wake("R9", 0, 0);
    endtask

    task automatic t_same_cycle();
        dispatch(0, 1, 13, 0, 0, 0, 0); complete(13); step(); exp_rdy[13] = 1;
        chk_wake("R10", 1, 0);
        step();
        dispatch(1, 1, 14, 0, 0, 0, 0); step();
        chk_wake("R3", 0, 0);
        dispatch(2, 0, 0, 0, 0, 1, 14); complete(14); step();
        chk_wake("R10", 1, 1);
        check("R10", "dst_conflict", int'(dst_conflict), 0);
        check("R10", "reg_ready[14]", int'(reg_ready[14]), 0);
        step(); chk_wake("R9", 1, 2);
        step(); chk_wake("R9", 0, 0);
        check("R10", "reg_ready", int'(reg_ready), int'(exp_rdy));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        exp_rdy = '0;
        rst_n = 0;
        clr_in();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_ready_at_dispatch();
        t_wait_two_regs();
        t_same_reg_twice();
        t_untracked();
        t_conflict();
        t_squash();
        t_burst();
        t_same_cycle();
        finish_run();
    end
endmodule